// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address that one port of a synchronous memory uses for each access. At every rising clock edge it samples three active-low controls and picks the address for the access launched at that edge. It can take a fresh address from the external bus, step its internal counter by one, repeat the previous address, or return to zero. The chosen value is held in a register and driven to the memory array until the next edge. A burst therefore needs only one external address followed by step cycles.

The two chip-select inputs of the port are brought into the block so that the port boundary is complete. They have no influence on the counter, so a deselected port keeps tracking its burst position. Clearing the counter costs no cycle, because the access made in the clearing cycle itself already goes to location zero.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous active-high `rst` is high at a rising edge, `cur_addr` becomes zero.
- R2: When `load_n` is 0 and `clear_n` is 1 at a rising edge, `cur_addr` takes the value of `ext_addr` sampled at that edge.
- R3: When `clear_n` and `load_n` are 1 and `step_n` is 0 at a rising edge, `cur_addr` becomes its previous value plus one.
- R4: When `clear_n`, `load_n` and `step_n` are all 1 at a rising edge, `cur_addr` keeps its previous value.
- R5: When `clear_n` is 0 at a rising edge, `cur_addr` becomes zero whatever `load_n`, `step_n` and `ext_addr` are, so the access of that same cycle targets location zero.
- R6: When `load_n` and `step_n` are both 0 with `clear_n` at 1, the load wins and `cur_addr` equals `ext_addr`, not the previous value plus one.
- R7: A step from the all-ones address gives zero.
- R8: The chip-select inputs `sel0_n` and `sel1` have no effect; the results of R2 to R7 are the same for every combination of them.
- R9: `cur_addr` changes only at rising clock edges; control changes between edges have no effect until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all controls sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | External address, taken when the load control is asserted |
| load_n | input | 1 | Active-low address load |
| step_n | input | 1 | Active-low counter advance |
| clear_n | input | 1 | Active-low counter clear, highest priority |
| sel0_n | input | 1 | Active-low chip select, ignored by the counter |
| sel1 | input | 1 | Active-high chip select, ignored by the counter |
| cur_addr | output | ADDR_W | Address used for the access of the current cycle |

## Verification
The bench goes after the priority collisions: clear with load and step both asserted, where a design with the wrong order would show the external address or an incremented value instead of zero, and load together with step, where a reversed order would show the old address plus one. It steps across the all-ones address, which a counter with a width slip would carry into a wrong value instead of zero. It deasserts both chip selects during loads, steps and clears, which a design that gated the counter would answer by freezing the address. It also runs long random stretches of all control combinations, compared on every clock against a behavioural model, to catch a hold that drifts or a clear that lags by a cycle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Operation chosen at one clock edge, in priority order
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_KEEP  = 2'd3
    } addr_op_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic step;
    } ctl_req_t;

    // Fixed priority: clear, then load, then step, then keep
    function automatic addr_op_e pick_op(input ctl_req_t req);
        if (req.clear)      return OP_CLEAR;
        else if (req.load)  return OP_LOAD;
        else if (req.step)  return OP_STEP;
        else                return OP_KEEP;
    endfunction

endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
    import burst_addr_pkg::*;
(
    input  logic     load_n,
    input  logic     step_n,
    input  logic     clear_n,
    output addr_op_e op
);

    ctl_req_t req;

    always_comb begin
        req.clear = ~clear_n;
        req.load  = ~load_n;
        req.step  = ~step_n;
        op        = pick_op(req);
    end

endmodule

// File: rtl/burst_addr_count.sv
module burst_addr_count
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  addr_op_e          op,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_q
);

    localparam logic [ADDR_W-1:0] ZERO = '0;
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        unique case (op)
            OP_CLEAR: addr_d = ZERO;
            OP_LOAD:  addr_d = ext_addr;
            OP_STEP:  addr_d = addr_q + ONE;   // wraps naturally at all-ones
            default:  addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= ZERO;
        else     addr_q <= addr_d;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              load_n,
    input  logic              step_n,
    input  logic              clear_n,
    input  logic              sel0_n,
    input  logic              sel1,
    output logic [ADDR_W-1:0] cur_addr
);

    addr_op_e op;

    // Chip selects belong to the port but never gate the counter
    logic sel_unused;
    assign sel_unused = sel0_n ^ sel1;

    burst_addr_decode u_decode (
        .load_n  (load_n),
        .step_n  (step_n),
        .clear_n (clear_n),
        .op      (op)
    );

    burst_addr_count #(.ADDR_W(ADDR_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ext_addr (ext_addr),
        .addr_q   (cur_addr)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              load_n,
    input logic              step_n,
    input logic              clear_n,
    input logic [ADDR_W-1:0] cur_addr
);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> cur_addr == '0);

    // R2
    load_takes_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !load_n) |=> cur_addr == $past(ext_addr));

    // R3
    step_adds_one_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && !step_n) |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

    // R4
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && step_n) |=> $stable(cur_addr));

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> cur_addr == '0);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_addr (ext_addr),
    .load_n   (load_n),
    .step_n   (step_n),
    .clear_n  (clear_n),
    .cur_addr (cur_addr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] ext_addr;
    logic         load_n, step_n, clear_n, sel0_n, sel1;
    logic [W-1:0] cur_addr;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] model = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    burst_addr_gen #(.ADDR_W(W)) u_dut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr),
        .load_n(load_n), .step_n(step_n), .clear_n(clear_n),
        .sel0_n(sel0_n), .sel1(sel1), .cur_addr(cur_addr)
    );

    task automatic check(input string tag, input logic [W-1:0] exp);
        n_checks++;
        if (cur_addr !== exp) begin
            n_fail++;
            $display("FAIL %s: cur_addr=%h expected=%h", tag, cur_addr, exp);
        end
    endtask

    // Drive one cycle at a falling edge, update the model for the next
    // rising edge, then compare at the following falling edge.
    task automatic cycle(input logic l, input logic s, input logic c,
                         input logic [W-1:0] a, input logic s0, input logic s1,
                         input string tag);
        load_n = l; step_n = s; clear_n = c; ext_addr = a;
        sel0_n = s0; sel1 = s1;
        if (!c)      model = '0;
        else if (!l) model = a;
        else if (!s) model = model + 1'b1;
        @(negedge clk);
        check(tag, model);
    endtask

    initial begin
        rst = 1'b1; load_n = 1'b1; step_n = 1'b1; clear_n = 1'b1;
        sel0_n = 1'b0; sel1 = 1'b1; ext_addr = 16'hA5A5;
        repeat (3) @(negedge clk);
        check("R1 reset", '0);
        rst = 1'b0;
        model = '0;

        cycle(0, 1, 1, 16'h1230, 0, 1, "R2 load");
        cycle(1, 0, 1, 16'hFFFF, 0, 1, "R3 step");
        cycle(1, 0, 1, 16'h0000, 0, 1, "R3 step");
        cycle(1, 1, 1, 16'h7777, 0, 1, "R4 hold");
        cycle(1, 1, 1, 16'h8888, 0, 1, "R4 hold");
        check("R4 hold value", 16'h1232);
        cycle(0, 0, 1, 16'h0400, 0, 1, "R6 load over step");
        check("R6 value", 16'h0400);
        cycle(0, 0, 0, 16'h5555, 0, 1, "R5 clear over all");
        check("R5 value", 16'h0000);
        cycle(1, 0, 1, 16'h5555, 0, 1, "R5 no dead cycle");
        check("R5 next", 16'h0001);
        cycle(0, 1, 1, 16'hFFFE, 0, 1, "R7 load");
        cycle(1, 0, 1, 16'h0000, 0, 1, "R7 step");
        cycle(1, 0, 1, 16'h0000, 0, 1, "R7 wrap");
        check("R7 wrap value", 16'h0000);
        cycle(0, 1, 1, 16'h0900, 1, 0, "R8 load deselected");
        cycle(1, 0, 1, 16'h0000, 1, 1, "R8 step deselected");
        cycle(1, 1, 1, 16'h0000, 0, 0, "R8 hold deselected");
        check("R8 value", 16'h0901);
        cycle(1, 1, 0, 16'h0000, 1, 0, "R8 clear deselected");

        // R9: toggle controls mid-cycle, output must stay put until the edge
        cycle(0, 1, 1, 16'h0333, 0, 1, "R9 load");
        #0.5 load_n = 1'b0; ext_addr = 16'h0444; clear_n = 1'b0;
        #0.5 load_n = 1'b1; clear_n = 1'b1; step_n = 1'b1;
        check("R9 mid-cycle", 16'h0333);
        @(negedge clk);
        check("R9 after edge hold", 16'h0333);

        for (int i = 0; i < 2000; i++) begin
            logic l, s, c;
            string tag;
            c = ($urandom_range(0, 9) != 0);
            l = ($urandom_range(0, 3) != 0);
            s = $urandom_range(0, 1);
            if (!c)      tag = "R5 random";
            else if (!l) tag = "R2 random";
            else if (!s) tag = "R3 random";
            else         tag = "R4 random";
            cycle(l, s, c, 16'($urandom), 1'($urandom), 1'($urandom), tag);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule